// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits on the byte-wide bus of a small 8-bit processor and drives a serial flash over a four-wire SPI link. Software loads up to three address bytes, then writes one opcode into the command location. That write starts the whole transaction without further help: the block lowers chip select, shifts out the opcode, adds whatever address, zero or dummy bytes that opcode needs, and then moves data through a one-byte transmit holding register or a one-byte receive register.

Software follows progress by polling a status byte. Opcodes whose data length is open (streaming read, fast read, page program) stay active with chip select low. They end only when software writes the pseudo-opcode 0xFF. During a streaming read the link stops between bytes until the previous byte has been read. During programming it stops, and says so in status, until the next transmit byte arrives.

The serial link uses mode 0 (clock idles low, data sampled on the rising edge) with the most significant bit first. Each clock half-period lasts `SCK_DIV` system clocks.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the status byte reads 0x02.
- R2: A read at offset 0x19 returns status, with bit 0 = busy (command active), bit 1 = transmit register empty, bit 2 = receive byte ready and bit 3 = stalled waiting for transmit data; every other bit reads 0. A read at offset 0x18 returns the receive byte. A read at any other offset returns 0x00.
- R3: Writing opcode 0x06, 0x04, 0xC7, 0xB9, or any opcode outside the supported set other than 0xFF, produces a frame that holds only that opcode. Chip select is then released.
- R4: Opcode 0x01 sends the opcode and then the byte held in the transmit register (written at offset 0x38). Taking that byte sets the transmit-empty bit.
- R5: Opcode 0xD8 sends the opcode and then the address bytes written at offsets 0x3C, 0x3B and 0x3A, in that order (high, mid, low).
- R6: Opcode 0x05 sends the opcode plus one 0x00 filler byte, and places the byte received during the filler in the receive register. Opcode 0xAB sends the opcode, three 0x00 bytes and one filler, and keeps the byte received during the filler.
- R7: Opcode 0x03 sends the opcode and the three address bytes. Opcode 0x0B also adds one 0x00 byte after the address. Both then receive bytes without limit, and no new byte starts while the receive-ready bit is set. Reading offset 0x18 clears receive-ready.
- R8: Opcode 0x02 sends the opcode and the three address bytes, then one transmit-register byte per frame byte. While the transmit register is empty the link stops and status bit 3 is set.
- R9: Writing 0xFF to offset 0x39 returns the block to idle on the next clock, even in the middle of a byte: chip select goes high and the serial clock goes low.
- R10: A command write other than 0xFF while a command is active is ignored.
- R11: The serial clock is low whenever chip select is high. The data output changes only while the serial clock is low. Chip select falls only after a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (reading receive data clears it) |
| bus_addr | input | 8 | Register offset within the peripheral page |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions take for granted that each bus strobe lasts one clock. They also assume a receive-register read never coincides with the arrival of a byte, which holds because a receive byte only starts when the ready bit is clear. The flash side is assumed to change its data only at chip-select fall or on a falling serial clock. The bench's flash model keeps to that rule. Its bus tasks drive one strobe per access, between clock edges. Read and write are never pulsed in the same cycle.

// File: rtl/spi_seq_pkg.sv
// Shared definitions for the serial flash sequencer: register offsets,
// byte phases and the per-opcode transfer plan.
// Assumes an 8-bit offset within the peripheral page.
package spi_seq_pkg;

    localparam logic [7:0] OFS_TX   = 8'h38;
    localparam logic [7:0] OFS_CMD  = 8'h39;
    localparam logic [7:0] OFS_ALO  = 8'h3A;
    localparam logic [7:0] OFS_AMID = 8'h3B;
    localparam logic [7:0] OFS_AHI  = 8'h3C;
    localparam logic [7:0] OFS_RX   = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h19;
    localparam logic [7:0] OP_END   = 8'hFF;

    typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_TXD, PH_RXD} phase_t;
    typedef enum logic [2:0] {DM_NONE, DM_TX1, DM_TXS, DM_RX1, DM_RXS} dmode_t;

    typedef struct packed {
        logic   has_adr;   // three address-slot bytes follow the opcode
        logic   adr_zero;  // address slots carry zeros instead of the address
        logic   has_dum;   // one zero byte after the address slots
        dmode_t dm;        // kind of data phase
    } plan_t;

    // Map an opcode to its byte sequence; unknown opcodes send the opcode only.
    function automatic plan_t decode_op(input logic [7:0] op);
        plan_t p;
        p = '{has_adr: 1'b0, adr_zero: 1'b0, has_dum: 1'b0, dm: DM_NONE};
        case (op)
            8'h01: p.dm = DM_TX1;
            8'hD8: p.has_adr = 1'b1;
            8'h02: begin p.has_adr = 1'b1; p.dm = DM_TXS; end
            8'h05: p.dm = DM_RX1;
            8'hAB: begin p.has_adr = 1'b1; p.adr_zero = 1'b1; p.dm = DM_RX1; end
            8'h03: begin p.has_adr = 1'b1; p.dm = DM_RXS; end
            8'h0B: begin p.has_adr = 1'b1; p.has_dum = 1'b1; p.dm = DM_RXS; end
            default: p.dm = DM_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_seq_shift.sv
// Byte shift engine, SPI mode 0, MSB first. Each clock half-period lasts DIV
// system clocks. It samples miso as sclk rises and shifts mosi as sclk falls.
// Assumes start is only asserted while idle; abort wins over everything.
module spi_seq_shift #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          act_q;
    logic [CW-1:0] div_q;
    logic [3:0]    half_q;
    logic [7:0]    sreg_q;
    logic [7:0]    rsh_q;

    // Half-period timing, edge generation and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            div_q  <= '0;
            half_q <= '0;
            sreg_q <= '0;
            rsh_q  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                act_q <= 1'b0;
                sclk  <= 1'b0;
                div_q <= '0;
            end else if (!act_q) begin
                if (start) begin
                    act_q  <= 1'b1;
                    sreg_q <= tx_byte;
                    div_q  <= '0;
                    half_q <= '0;
                end
            end else if (div_q == CW'(DIV - 1)) begin
                div_q  <= '0;
                half_q <= half_q + 4'd1;
                if (!half_q[0]) begin
                    sclk  <= 1'b1;
                    rsh_q <= {rsh_q[6:0], miso};
                end else begin
                    sclk   <= 1'b0;
                    sreg_q <= {sreg_q[6:0], 1'b0};
                    if (half_q == 4'd15) begin
                        act_q <= 1'b0;
                        done  <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    assign mosi    = sreg_q[7];
    assign rx_byte = rsh_q;

endmodule

// File: rtl/spi_seq_regs.sv
// Bus-facing registers: address bytes, transmit holding byte, receive byte,
// and the status read mux. Assumes one-cycle strobes; reading the receive
// offset clears receive-ready.
module spi_seq_regs
    import spi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tx_take,
    input  logic        rx_load,
    input  logic [7:0]  rx_in,
    input  logic        st_busy,
    input  logic        st_wait,
    output logic [23:0] adr,
    output logic [7:0]  tx_q,
    output logic        tx_full,
    output logic        rx_full
);
    logic [7:0] rx_q;

    // Register writes and the set/clear of the two holding flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr     <= '0;
            tx_q    <= '0;
            tx_full <= 1'b0;
            rx_q    <= '0;
            rx_full <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_AHI)  adr[23:16] <= bus_wdata;
            if (bus_wr && bus_addr == OFS_AMID) adr[15:8]  <= bus_wdata;
            if (bus_wr && bus_addr == OFS_ALO)  adr[7:0]   <= bus_wdata;
            if (bus_wr && bus_addr == OFS_TX) begin
                tx_q    <= bus_wdata;
                tx_full <= 1'b1;
            end else if (tx_take) begin
                tx_full <= 1'b0;
            end
            if (rx_load) begin
                rx_q    <= rx_in;
                rx_full <= 1'b1;
            end else if (bus_rd && bus_addr == OFS_RX) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Read mux for the two readable offsets.
    always_comb begin
        case (bus_addr)
            OFS_STAT: bus_rdata = {4'b0000, st_wait, rx_full, !tx_full, st_busy};
            OFS_RX:   bus_rdata = rx_q;
            default:  bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_seq_ctrl.sv
// Per-opcode sequencer. A command write latches the opcode and its plan,
// then each byte is issued to the shift engine in turn. It stalls on an
// empty transmit register or an unread receive byte. The terminating
// opcode aborts from any state. Assumes address bytes are loaded beforehand.
module spi_seq_ctrl
    import spi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [7:0]  cmd_byte,
    input  logic [23:0] adr,
    input  logic [7:0]  tx_q,
    input  logic        tx_full,
    input  logic        rx_full,
    input  logic        sh_done,
    output logic        sh_start,
    output logic        sh_abort,
    output logic [7:0]  sh_tx,
    output logic        tx_take,
    output logic        rx_load,
    output logic        cs_n,
    output logic        busy,
    output logic        waiting
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_SHIFT} state_t;

    state_t     state_q;
    phase_t     phase_q;
    plan_t      plan_q;
    logic [7:0] op_q;
    logic [1:0] idx_q;
    logic       issue_ok;
    logic       nxt_end;
    phase_t     nxt_phase;
    logic [1:0] nxt_idx;

    assign sh_abort = cmd_wr && cmd_byte == OP_END;

    // Pick the byte for the current phase and whether it may start now.
    always_comb begin
        issue_ok = 1'b1;
        sh_tx    = 8'h00;
        case (phase_q)
            PH_OPC: sh_tx = op_q;
            PH_ADR: if (!plan_q.adr_zero)
                        sh_tx = (idx_q == 2'd0) ? adr[23:16] :
                                (idx_q == 2'd1) ? adr[15:8] : adr[7:0];
            PH_TXD: begin issue_ok = tx_full; sh_tx = tx_q; end
            PH_RXD: issue_ok = !rx_full;
            default: sh_tx = 8'h00;
        endcase
    end

    // Work out the phase that follows the byte now finishing.
    always_comb begin
        phase_t data_ph;
        logic   data_none;
        data_none = (plan_q.dm == DM_NONE);
        data_ph   = (plan_q.dm == DM_TX1 || plan_q.dm == DM_TXS) ? PH_TXD : PH_RXD;
        nxt_end   = 1'b0;
        nxt_idx   = 2'd0;
        nxt_phase = phase_q;
        case (phase_q)
            PH_OPC: begin
                if (plan_q.has_adr)      nxt_phase = PH_ADR;
                else if (plan_q.has_dum) nxt_phase = PH_DUM;
                else begin nxt_phase = data_ph; nxt_end = data_none; end
            end
            PH_ADR: begin
                if (idx_q != 2'd2) begin nxt_phase = PH_ADR; nxt_idx = idx_q + 2'd1; end
                else if (plan_q.has_dum) nxt_phase = PH_DUM;
                else begin nxt_phase = data_ph; nxt_end = data_none; end
            end
            PH_DUM:  begin nxt_phase = data_ph; nxt_end = data_none; end
            PH_TXD:  nxt_end = (plan_q.dm == DM_TX1);
            PH_RXD:  nxt_end = (plan_q.dm == DM_RX1);
            default: nxt_end = 1'b1;
        endcase
    end

    assign sh_start = (state_q == S_ISSUE) && issue_ok && !sh_abort;
    assign tx_take  = sh_start && phase_q == PH_TXD;
    assign rx_load  = (state_q == S_SHIFT) && sh_done && phase_q == PH_RXD && !sh_abort;
    assign busy     = (state_q != S_IDLE);
    assign waiting  = (state_q == S_ISSUE) && phase_q == PH_TXD && !tx_full;

    // Command launch, byte-to-byte stepping, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_OPC;
            plan_q  <= '0;
            op_q    <= '0;
            idx_q   <= '0;
            cs_n    <= 1'b1;
        end else if (sh_abort) begin
            state_q <= S_IDLE;
            cs_n    <= 1'b1;
        end else begin
            case (state_q)
                S_IDLE: if (cmd_wr) begin
                    op_q    <= cmd_byte;
                    plan_q  <= decode_op(cmd_byte);
                    phase_q <= PH_OPC;
                    idx_q   <= 2'd0;
                    cs_n    <= 1'b0;
                    state_q <= S_ISSUE;
                end
                S_ISSUE: if (sh_start) state_q <= S_SHIFT;
                S_SHIFT: if (sh_done) begin
                    if (nxt_end) begin
                        state_q <= S_IDLE;
                        cs_n    <= 1'b1;
                    end else begin
                        phase_q <= nxt_phase;
                        idx_q   <= nxt_idx;
                        state_q <= S_ISSUE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_flash_seq.sv
// Top level of the serial flash command sequencer: register block,
// per-opcode sequencer and byte shift engine. Assumes a single-clock
// system with synchronous active-low reset.
module spi_flash_seq
    import spi_seq_pkg::*;
#(
    parameter int SCK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic [23:0] adr;
    logic [7:0]  tx_q, sh_tx, rx_byte;
    logic        tx_full, rx_full, tx_take, rx_load;
    logic        sh_start, sh_abort, sh_done, busy, waiting;
    logic        cmd_wr;

    assign cmd_wr = bus_wr && bus_addr == OFS_CMD;

    spi_seq_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_take(tx_take), .rx_load(rx_load), .rx_in(rx_byte),
        .st_busy(busy), .st_wait(waiting),
        .adr(adr), .tx_q(tx_q), .tx_full(tx_full), .rx_full(rx_full)
    );

    spi_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_byte(bus_wdata), .adr(adr),
        .tx_q(tx_q), .tx_full(tx_full), .rx_full(rx_full),
        .sh_done(sh_done), .sh_start(sh_start), .sh_abort(sh_abort),
        .sh_tx(sh_tx), .tx_take(tx_take), .rx_load(rx_load),
        .cs_n(spi_cs_n), .busy(busy), .waiting(waiting)
    );

    spi_seq_shift #(.DIV(SCK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .abort(sh_abort), .tx_byte(sh_tx),
        .done(sh_done), .rx_byte(rx_byte),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

endmodule

// File: rtl/spi_flash_seq_chk.sv
// Property checker for spi_flash_seq, attached with bind below.
// Assumes one-cycle bus strobes.
module spi_flash_seq_chk
    import spi_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       rx_full
);
    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R11
    cs_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(bus_wr && bus_addr == OFS_CMD && bus_wdata != OP_END));

    // R9
    end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata == OP_END) |=> (spi_cs_n && !spi_sclk));

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RX && rx_full) |=> !rx_full);

endmodule

bind spi_flash_seq spi_flash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .rx_full(rx_full)
);

// File: tb/tb_spi_flash_seq.sv
`timescale 1ns/1ps
module tb_spi_flash_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0, errors = 0;

    spi_flash_seq #(.SCK_DIV(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    // Flash model: records each frame and answers byte k with resp(k).
    logic [7:0] fb [0:299];
    int         fcnt = 0, bitc = 0;
    logic [7:0] cur = 8'h00, outb = 8'h00;

    function automatic logic [7:0] resp(input int k);
        return 8'((k * 29 + 65) & 255);
    endfunction

    always @(negedge spi_cs_n) begin
        fcnt = 0; bitc = 0; outb = resp(0); spi_miso = outb[7];
    end
    always @(posedge spi_sclk) begin
        cur = {cur[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            if (fcnt < 300) fb[fcnt] = cur;
            fcnt++; bitc = 0;
        end
    end
    always @(negedge spi_sclk) begin
        if (bitc == 0) outb = resp(fcnt);
        else           outb = {outb[6:0], 1'b0};
        spi_miso = outb[7];
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_stat(input string req, input logic [7:0] mask, input logic [7:0] val);
        logic [7:0] s;
        for (int n = 0; n < 3000; n++) begin
            bus_read(8'h19, s);
            if ((s & mask) == val) return;
        end
        check(req, int'(s & mask), int'(val));
    endtask

    task automatic set_adr(input logic [23:0] a);
        bus_write(8'h3C, a[23:16]);
        bus_write(8'h3B, a[15:8]);
        bus_write(8'h3A, a[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        logic [7:0] sops [6];
        sops = '{8'h06, 8'h04, 8'hC7, 8'hB9, 8'h5A, 8'h00};
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", spi_cs_n, 1);
        check("R1 sclk", spi_sclk, 0);
        bus_read(8'h19, s); check("R1 status", s, 8'h02);
        bus_read(8'h38, s); check("R2 unmapped offset", s, 0);

        // R3 single-byte opcodes, including unlisted ones
        foreach (sops[i]) begin
            bus_write(8'h39, sops[i]);
            wait_stat("R3 finish", 8'h01, 8'h00);
            check("R3 frame length", fcnt, 1);
            check("R3 opcode", fb[0], sops[i]);
            check("R3 cs released", spi_cs_n, 1);
        end

        // R4 status write with one transmit byte
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            v = 8'(i * 71 + 3);
            bus_write(8'h38, v);
            bus_read(8'h19, s); check("R4 tx loaded", s, 8'h00);
            bus_write(8'h39, 8'h01);
            wait_stat("R4 finish", 8'h01, 8'h00);
            check("R4 frame length", fcnt, 2);
            check("R4 data byte", fb[1], v);
            bus_read(8'h19, s); check("R4 tx empty", s, 8'h02);
        end

        // R5 sector erase address order
        for (int k = 0; k < 4; k++) begin
            logic [23:0] a;
            a = 24'(k * 24'h110B07 + 24'h0F0102);
            set_adr(a);
            bus_write(8'h39, 8'hD8);
            wait_stat("R5 finish", 8'h01, 8'h00);
            check("R5 frame length", fcnt, 4);
            check("R5 high", fb[1], a[23:16]);
            check("R5 mid", fb[2], a[15:8]);
            check("R5 low", fb[3], a[7:0]);
        end

        // R6 one-byte reads
        bus_write(8'h39, 8'h05);
        wait_stat("R6 finish", 8'h01, 8'h00);
        check("R6 rdsr length", fcnt, 2);
        check("R6 rdsr filler", fb[1], 0);
        bus_read(8'h19, s); check("R2 rx ready status", s, 8'h06);
        bus_read(8'h18, d); check("R6 rdsr data", d, resp(1));
        bus_read(8'h19, s); check("R7 read clears ready", s, 8'h02);

        set_adr(24'hA5C3E1);
        bus_write(8'h39, 8'hAB);
        wait_stat("R6 finish", 8'h01, 8'h00);
        check("R6 res length", fcnt, 5);
        for (int j = 1; j < 5; j++) check("R6 res zero bytes", fb[j], 0);
        bus_read(8'h18, d); check("R6 res data", d, resp(4));

        // R7 streaming read with stall, ignored command, and terminate
        set_adr(24'h0F1234);
        bus_write(8'h39, 8'h03);
        for (int i = 0; i < 6; i++) begin
            wait_stat("R7 rx ready", 8'h04, 8'h04);
            repeat (40) @(negedge clk);
            check("R7 stalled count", fcnt, 5 + i);
            if (i == 2) bus_write(8'h39, 8'h06); // R10 ignored
            bus_read(8'h18, d); check("R7 data", d, resp(4 + i));
        end
        check("R7 addr high", fb[1], 8'h0F);
        check("R7 addr low", fb[3], 8'h34);
        bus_write(8'h39, 8'hFF);
        check("R9 cs after end", spi_cs_n, 1);
        check("R9 sclk after end", spi_sclk, 0);
        bus_read(8'h19, s); check("R9 idle status", s, 8'h02);

        // R7 fast read with dummy byte
        set_adr(24'h0F0080);
        bus_write(8'h39, 8'h0B);
        for (int i = 0; i < 3; i++) begin
            wait_stat("R7 rx ready", 8'h04, 8'h04);
            repeat (40) @(negedge clk);
            check("R7 fast stalled count", fcnt, 6 + i);
            bus_read(8'h18, d); check("R7 fast data", d, resp(5 + i));
        end
        check("R7 fast dummy", fb[4], 0);
        bus_write(8'h39, 8'hFF);

        // R8 page program streaming with stall on empty transmit register
        set_adr(24'h0F2200);
        bus_write(8'h39, 8'h02);
        wait_stat("R8 stall", 8'h0F, 8'h0B);
        check("R8 addr bytes only", fcnt, 4);
        bus_write(8'h39, 8'h04); // R10 ignored while active
        repeat (80) @(negedge clk);
        bus_read(8'h19, s); check("R10 still stalled", s, 8'h0B);
        check("R10 no extra bytes", fcnt, 4);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] v;
            v = 8'(i * 53 + 17);
            bus_write(8'h38, v);
            repeat (2) @(negedge clk);
            wait_stat("R8 stall", 8'h0F, 8'h0B);
            check("R8 count", fcnt, 5 + i);
            check("R8 data", fb[4 + i], v);
        end
        bus_write(8'h39, 8'hFF);
        check("R9 cs after program", spi_cs_n, 1);

        // R9 abort in the middle of a byte
        bus_write(8'h39, 8'h03);
        repeat (8) @(negedge clk);
        check("R9 mid-byte active", spi_cs_n, 0);
        bus_write(8'h39, 8'hFF);
        check("R9 abort cs", spi_cs_n, 1);
        check("R9 abort sclk", spi_sclk, 0);
        check("R9 no byte finished", fcnt, 0);
        repeat (60) @(negedge clk);
        bus_read(8'h19, s); check("R9 abort status", s, 8'h02);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule